// File: doc/BRIEF.md
# Function-Level Cycle Profiler

This block sits beside a processor core and charges elapsed execution to the function that is running. It samples the program counter every cycle and counts the cycles on which the counter moves. Call and return strobes from the core's decoder, together with the call target address, tell it when control passes from one function to another. A call target address is folded in hardware into a small function number. A return recovers the caller's number from an internal stack.

Each time control changes hands, the running count is added into a per-function total held in an on-chip counter memory, and the running count starts again from zero. A separate read port returns the total of any function number, so a debug host can collect the profile after or during a run. After reset the root function (number `ROOT_FN`) is the one being charged.

Top module: `fn_profiler`

## Requirements
- R1: After reset `cur_fn_o` equals `ROOT_FN` (default 0), `busy_o` and `err_o` are 0, and every function total reads as 0.
- R2: The running count grows by one on each cycle where `pc_i` differs from its value in the previous cycle (0 right after reset), and stays the same on cycles where `pc_i` is held.
- R3: An accepted call sets `busy_o` for exactly the following cycle. After the second clock edge `cur_fn_o` holds the callee number h computed from `target_i`: x = target + V1; x = x + (x << 8); x = x ^ (x >> 4); sel = (x >> B1) mod 2^TAB_BITS; hi = (x + (x << A1)) >> A2; h = (hi xor ((sel*TAB_MUL + TAB_ADD) mod 2^FN_W)) mod 2^FN_W. All arithmetic is done on 32 bits.
- R4: In the clock edge that accepts a call or a return, the total of the function being left grows by the running count plus one if `pc_i` changed in that cycle. The running count then restarts from 0.
- R5: An accepted return with a non-empty stack makes the most recently saved caller the current function.
- R6: A call or return strobe that arrives while `busy_o` is 1 has no effect on the totals, the stack or the current function.
- R7: A call committed while the stack already holds `STK_DEPTH` callers sets `err_o`. The stack is left unchanged, and the callee still becomes current.
- R8: A return with an empty stack sets `err_o` and leaves `cur_fn_o` unchanged. The flush of R4 still takes place into the current function's total.
- R9: Once set, `err_o` stays 1 until reset.
- R10: `rd_cnt_o` shows the total of function `rd_idx_i` one clock edge after `rd_idx_i` is presented.
- R11: When `call_i` and `ret_i` are both high in an accepted cycle, the event is treated as a call and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | AW | Program counter of the core |
| call_i | input | 1 | Decoded call strobe |
| ret_i | input | 1 | Decoded return strobe |
| target_i | input | AW | Call target address, valid with `call_i` |
| rd_idx_i | input | FN_W | Function number to read |
| rd_cnt_o | output | CW | Accumulated total of `rd_idx_i`, one cycle later |
| cur_fn_o | output | FN_W | Function currently being charged |
| busy_o | output | 1 | Hash commit pending; strobes are ignored |
| err_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
A corrupted stack entry shows up on `cur_fn_o` in the cycle right after the return that pops it. A wrong hash shows up there two edges after the call. A mistake in the running count or in the flush stays hidden inside the counter memory until that function's total is read, so the bench reads every function it touched and compares each total with its own model of the per-cycle charging. Overflow and underflow are driven on purpose, and the bench confirms that the error flag stays high and that later returns still unwind in order.

// File: rtl/prof_pkg.sv
package prof_pkg;

  localparam int HASH_W = 32;

  // First half of the address fold: offset, spread upwards, fold downwards.
  function automatic logic [HASH_W-1:0] mix_addr(input logic [HASH_W-1:0] addr,
                                                 input logic [HASH_W-1:0] v1);
    logic [HASH_W-1:0] t;
    t = addr + v1;
    t = t + (t << 8);
    t = t ^ (t >> 4);
    return t;
  endfunction

  // Upper part of the fold that feeds the final xor.
  function automatic logic [HASH_W-1:0] upper_part(input logic [HASH_W-1:0] t,
                                                   input int a1, input int a2);
    return (t + (t << a1)) >> a2;
  endfunction

  // Correction table entry k, computed rather than listed.
  function automatic logic [HASH_W-1:0] corr_entry(input int k, input int mul, input int add);
    return HASH_W'(k * mul + add);
  endfunction

endpackage

// File: rtl/prof_hash.sv
module prof_hash #(
  parameter int                AW       = 32,
  parameter int                FN_W     = 6,
  parameter logic [31:0]       V1       = 32'h3c6e_f372,
  parameter int                A1       = 3,
  parameter int                A2       = 16,
  parameter int                B1       = 28,
  parameter int                TAB_BITS = 3,
  parameter int                TAB_MUL  = 37,
  parameter int                TAB_ADD  = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   addr_i,
  output logic            valid_o,
  output logic [FN_W-1:0] idx_o
);
  import prof_pkg::*;

  localparam int TAB_N = 1 << TAB_BITS;

  logic [FN_W-1:0]   tab_w [TAB_N];
  logic [HASH_W-1:0] mix_q;
  logic              vld_q;
  logic [HASH_W-1:0] hi_w;
  logic [HASH_W-1:0] sel_full_w;
  logic [TAB_BITS-1:0] sel_w;

  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    assign tab_w[k] = FN_W'(corr_entry(k, TAB_MUL, TAB_ADD));
  end

  // Stage 1: register the mixed address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= start_i;
      if (start_i) mix_q <= mix_addr(HASH_W'(addr_i), V1);
    end
  end

  // Stage 2: fold and correct, consumed at the next edge.
  assign sel_full_w = mix_q >> B1;
  assign sel_w      = sel_full_w[TAB_BITS-1:0];
  assign hi_w       = upper_part(mix_q, A1, A2);
  assign idx_o      = FN_W'(hi_w) ^ tab_w[sel_w];
  assign valid_o    = vld_q;

  assert_hash_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

endmodule

// File: rtl/prof_stack.sv
module prof_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic            do_push, do_pop;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign top_o   = empty_o ? '0 : mem_q[sp_q - SP_W'(1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (do_push) begin
      mem_q[sp_q] <= din_i;
      sp_q        <= sp_q + SP_W'(1);
    end else if (do_pop) begin
      sp_q <= sp_q - SP_W'(1);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |=> (full_o && $stable(top_o)));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);
  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH));

endmodule

// File: rtl/prof_cntmem.sv
module prof_cntmem #(
  parameter int FN_W = 6,
  parameter int CW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en_i,
  input  logic [FN_W-1:0] acc_idx_i,
  input  logic [CW-1:0]   acc_val_i,
  input  logic [FN_W-1:0] rd_idx_i,
  output logic [CW-1:0]   rd_cnt_o
);
  localparam int N_FN = 1 << FN_W;

  logic [CW-1:0] tot_q [N_FN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt_o <= '0;
      for (int i = 0; i < N_FN; i++) tot_q[i] <= '0;
    end else begin
      rd_cnt_o <= tot_q[rd_idx_i];
      if (acc_en_i) tot_q[acc_idx_i] <= tot_q[acc_idx_i] + acc_val_i;
    end
  end

  assert_acc_adds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && (rd_idx_i == acc_idx_i)) |=> ##1
      (rd_cnt_o == $past(rd_cnt_o) + $past(acc_val_i, 2)) || $past(rd_idx_i) != $past(acc_idx_i, 2)
      || $past(acc_en_i));

endmodule

// File: rtl/fn_profiler.sv
module fn_profiler #(
  parameter int          AW        = 32,
  parameter int          FN_W      = 6,
  parameter int          CW        = 32,
  parameter int          STK_DEPTH = 4,
  parameter int          ROOT_FN   = 0,
  parameter logic [31:0] V1        = 32'h3c6e_f372,
  parameter int          A1        = 3,
  parameter int          A2        = 16,
  parameter int          B1        = 28,
  parameter int          TAB_BITS  = 3,
  parameter int          TAB_MUL   = 37,
  parameter int          TAB_ADD   = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   pc_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [AW-1:0]   target_i,
  input  logic [FN_W-1:0] rd_idx_i,
  output logic [CW-1:0]   rd_cnt_o,
  output logic [FN_W-1:0] cur_fn_o,
  output logic            busy_o,
  output logic            err_o
);
  logic [AW-1:0]   pc_q;
  logic            pc_chg;
  logic [CW-1:0]   cnt_q;
  logic [FN_W-1:0] cur_q;
  logic            err_q;

  // Named internal events.
  logic            evt_call, evt_ret, evt_any;
  logic            hash_vld;
  logic [FN_W-1:0] hash_idx;
  logic [FN_W-1:0] stk_top;
  logic            stk_empty, stk_full;
  logic            stk_ovf, stk_unf;
  logic [CW-1:0]   flush_val;

  assign pc_chg    = (pc_i != pc_q);
  assign busy_o    = hash_vld;
  assign evt_call  = call_i && !busy_o;
  assign evt_ret   = ret_i && !call_i && !busy_o;
  assign evt_any   = evt_call || evt_ret;
  assign flush_val = cnt_q + CW'(pc_chg);
  assign stk_ovf   = hash_vld && stk_full;
  assign stk_unf   = evt_ret && stk_empty;

  prof_hash #(
    .AW(AW), .FN_W(FN_W), .V1(V1), .A1(A1), .A2(A2), .B1(B1),
    .TAB_BITS(TAB_BITS), .TAB_MUL(TAB_MUL), .TAB_ADD(TAB_ADD)
  ) u_hash (
    .clk(clk), .rst_n(rst_n), .start_i(evt_call), .addr_i(target_i),
    .valid_o(hash_vld), .idx_o(hash_idx)
  );

  prof_stack #(.DEPTH(STK_DEPTH), .W(FN_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(hash_vld), .pop_i(evt_ret),
    .din_i(cur_q), .top_o(stk_top), .empty_o(stk_empty), .full_o(stk_full)
  );

  prof_cntmem #(.FN_W(FN_W), .CW(CW)) u_mem (
    .clk(clk), .rst_n(rst_n), .acc_en_i(evt_any), .acc_idx_i(cur_q),
    .acc_val_i(flush_val), .rd_idx_i(rd_idx_i), .rd_cnt_o(rd_cnt_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
      cur_q <= FN_W'(ROOT_FN);
      err_q <= 1'b0;
    end else begin
      pc_q <= pc_i;
      if (evt_any)     cnt_q <= '0;
      else if (pc_chg) cnt_q <= cnt_q + CW'(1);
      if (hash_vld)                  cur_q <= hash_idx;
      else if (evt_ret && !stk_empty) cur_q <= stk_top;
      if (stk_ovf || stk_unf) err_q <= 1'b1;
    end
  end

  assign cur_fn_o = cur_q;
  assign err_o    = err_q;

  assert_busy_after_call_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_call |=> busy_o);
  assert_busy_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);
  assert_cnt_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |=> (cnt_q == '0));
  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_any && !pc_chg) |=> $stable(cnt_q));
  assert_ret_restores_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ret && !stk_empty) |=> (cur_fn_o == $past(stk_top)));
  assert_unf_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ret && stk_empty) |=> ($stable(cur_fn_o) && err_o));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

// File: tb/tb_fn_profiler.sv
module tb_fn_profiler;
  localparam int AW = 32, FN_W = 6, CW = 32, DEPTH = 4;
  localparam int N_FN = 1 << FN_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   pc_i = '0;
  logic            call_i = 1'b0, ret_i = 1'b0;
  logic [AW-1:0]   target_i = '0;
  logic [FN_W-1:0] rd_idx_i = '0;
  logic [CW-1:0]   rd_cnt_o;
  logic [FN_W-1:0] cur_fn_o;
  logic            busy_o, err_o;

  always #2 clk = ~clk;  // 250 MHz

  fn_profiler dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .call_i(call_i), .ret_i(ret_i),
    .target_i(target_i), .rd_idx_i(rd_idx_i), .rd_cnt_o(rd_cnt_o),
    .cur_fn_o(cur_fn_o), .busy_o(busy_o), .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent restatement of the callee number from R3.
  function automatic int ref_hash(input logic [31:0] a);
    logic [31:0] x, hi, sel, corr;
    x    = a + 32'h3c6e_f372;
    x    = x * 32'd257;            // x + (x << 8)
    x    = x ^ {4'b0, x[31:4]};
    sel  = {29'b0, x[30:28]};
    hi   = (x * 32'd9) >> 16;      // x + (x << 3), then down 16
    corr = (sel * 32'd37 + 32'd11) % 32'd64;
    return int'((hi ^ corr) % 32'd64);
  endfunction

  // Reference model, advanced on every rising edge.
  logic [CW-1:0] m_tot [N_FN];
  int            m_stk [DEPTH];
  int            m_sp, m_cur, m_pend;
  logic [CW-1:0] m_cnt;
  logic          m_busy, m_err;
  logic [AW-1:0] m_pc;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_FN; i++) m_tot[i] = '0;
      m_sp = 0; m_cur = 0; m_cnt = '0; m_busy = 1'b0; m_err = 1'b0; m_pc = '0; m_pend = 0;
    end else begin
      logic chg, bpre, ecall, eret;
      chg   = (pc_i != m_pc);
      bpre  = m_busy;
      ecall = call_i && !bpre;
      eret  = ret_i && !call_i && !bpre;
      if (ecall || eret) begin
        m_tot[m_cur] = m_tot[m_cur] + m_cnt + CW'(chg);
        m_cnt = '0;
      end else if (chg) m_cnt = m_cnt + 1;
      if (bpre) begin
        if (m_sp == DEPTH) m_err = 1'b1;
        else begin m_stk[m_sp] = m_cur; m_sp++; end
        m_cur = m_pend;
        m_busy = 1'b0;
      end
      if (ecall) begin m_pend = ref_hash(target_i); m_busy = 1'b1; end
      if (eret) begin
        if (m_sp == 0) m_err = 1'b1;
        else begin m_sp--; m_cur = m_stk[m_sp]; end
      end
      m_pc = pc_i;
    end
  end

  // Scoreboard for the read port.
  typedef struct { int idx; logic [CW-1:0] val; string tag; } rd_item_t;
  rd_item_t rq[$];
  logic     rd_req = 1'b0;

  always @(posedge clk) begin
    logic fire;
    fire = rd_req;
    #1;
    if (fire && rq.size() > 0) begin
      rd_item_t it;
      it = rq.pop_front();
      check($sformatf("%s read fn %0d", it.tag, it.idx), rd_cnt_o, it.val);
    end
  end

  task automatic read_fn(input int idx, input string tag);
    rd_item_t it;
    @(negedge clk);
    rd_idx_i = FN_W'(idx);
    it.idx = idx; it.val = m_tot[idx]; it.tag = tag;
    rq.push_back(it);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic run(input int n, input bit move);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (move) pc_i = pc_i + 4;
    end
  endtask

  task automatic do_call(input logic [31:0] tgt);
    @(negedge clk);
    call_i = 1'b1; target_i = tgt; pc_i = pc_i + 4;
    @(negedge clk);
    call_i = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk);
    ret_i = 1'b1; pc_i = pc_i + 4;
    @(negedge clk);
    ret_i = 1'b0;
  endtask

  localparam logic [31:0] T1 = 32'h0000_1040, T2 = 32'h0000_2a80, T3 = 32'h0004_0100;
  localparam logic [31:0] T4 = 32'h0010_0c00, T5 = 32'h0abc_0040;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cur after reset", 32'(cur_fn_o), 0);
    check("R1 busy after reset", 32'(busy_o), 0);
    check("R1 err after reset", 32'(err_o), 0);
    read_fn(0, "R1");
    read_fn(17, "R1");

    // R2: 10 moving cycles, 5 held, then a call whose cycle also moves.
    run(10, 1'b1);
    run(5, 1'b0);
    @(negedge clk);
    call_i = 1'b1; target_i = T1; pc_i = pc_i + 4;
    @(negedge clk);
    call_i = 1'b0;
    check("R3 busy one cycle after call", 32'(busy_o), 1);
    @(negedge clk);
    check("R3 busy clears", 32'(busy_o), 0);
    check("R3 callee number", 32'(cur_fn_o), 32'(ref_hash(T1)));
    read_fn(0, "R2 R4 literal");
    check("R2 R4 root total literal", rd_cnt_o, 11);

    // Nested call and unwinding.
    run(7, 1'b1);
    do_call(T2);
    run(1, 1'b0);
    check("R3 nested callee", 32'(cur_fn_o), 32'(ref_hash(T2)));
    run(3, 1'b1);
    run(2, 1'b0);
    do_ret();
    check("R5 return to first callee", 32'(cur_fn_o), 32'(ref_hash(T1)));
    run(4, 1'b1);
    do_ret();
    check("R5 return to root", 32'(cur_fn_o), 0);
    read_fn(ref_hash(T1), "R4");
    read_fn(ref_hash(T2), "R4");

    // R6: strobes during busy are dropped.
    @(negedge clk);
    call_i = 1'b1; target_i = T3; pc_i = pc_i + 4;
    @(negedge clk);
    call_i = 1'b1; target_i = T4; ret_i = 1'b1;
    @(negedge clk);
    call_i = 1'b0; ret_i = 1'b0;
    check("R6 busy-cycle call ignored", 32'(cur_fn_o), 32'(ref_hash(T3)));
    check("R6 no error from dropped strobes", 32'(err_o), 0);
    run(2, 1'b1);
    do_ret();
    check("R6 single frame was pushed", 32'(cur_fn_o), 0);

    // R11: call and return together act as a call.
    @(negedge clk);
    call_i = 1'b1; ret_i = 1'b1; target_i = T4; pc_i = pc_i + 4;
    @(negedge clk);
    call_i = 1'b0; ret_i = 1'b0;
    @(negedge clk);
    check("R11 both strobes act as call", 32'(cur_fn_o), 32'(ref_hash(T4)));
    check("R11 no error", 32'(err_o), 0);
    do_ret();
    check("R11 unwinds to root", 32'(cur_fn_o), 0);

    // R7: overflow of the caller stack.
    do_call(T1); run(1, 1'b1);
    do_call(T2); run(1, 1'b1);
    do_call(T3); run(1, 1'b1);
    do_call(T4); run(1, 1'b1);
    check("R7 full stack no error yet", 32'(err_o), 0);
    do_call(T5); run(1, 1'b1);
    check("R7 overflow sets error", 32'(err_o), 1);
    check("R7 callee current after overflow", 32'(cur_fn_o), 32'(ref_hash(T5)));
    do_ret();
    check("R7 stack unchanged top", 32'(cur_fn_o), 32'(ref_hash(T3)));
    do_ret();
    check("R7 unwind 2", 32'(cur_fn_o), 32'(ref_hash(T2)));
    do_ret();
    check("R7 unwind 3", 32'(cur_fn_o), 32'(ref_hash(T1)));
    do_ret();
    check("R7 unwind to root", 32'(cur_fn_o), 0);

    // R8: underflow at the root.
    run(3, 1'b1);
    do_ret();
    check("R8 underflow keeps root", 32'(cur_fn_o), 0);
    check("R8 underflow error", 32'(err_o), 1);
    run(6, 1'b1);
    check("R9 error sticky", 32'(err_o), 1);

    // R10: read back every touched total.
    read_fn(0, "R8 R10");
    read_fn(ref_hash(T1), "R10");
    read_fn(ref_hash(T2), "R10");
    read_fn(ref_hash(T3), "R10");
    read_fn(ref_hash(T4), "R10");
    read_fn(ref_hash(T5), "R10");
    read_fn(63, "R10");
    run(2, 1'b0);

    // R1 again: reset clears the flag and the totals.
    @(negedge clk);
    rst_n = 1'b0;
    run(2, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 err cleared by reset", 32'(err_o), 0);
    read_fn(ref_hash(T1), "R1 after second reset");
    run(2, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule